// File: doc/BRIEF.md
# Outbound Address Window Decoder

This block sits at the outbound side of a bus bridge. It holds a small bank of programmable address windows and decides, for a 64-bit request address, which window claims it. The windows are a configuration-space window, a message window, a parameterised number of outbound memory windows (three by default) and a local register window. Each window has a 64-bit base and a mask. Software writes them as 32-bit registers and can read them back.

Bit 0 of a mask enables its window. The window size is the two's complement of the mask with bit 0 cleared. The configuration, message and register windows keep a 32-bit mask, so their size is computed in 32 bits. The outbound memory windows keep a 64-bit mask. The register window has one special case: a mask of exactly 0x7001 selects a fixed window of 4096 bytes.

The lookup is combinational from the window registers. It returns a hit flag, the index of the window that won and the byte offset of the address inside that window. A chip carries one instance per bridge port. Every instance uses the same register layout.

Top module: `outbound_window_decoder`

## Requirements
- R1: After reset every register reads 0 and no address hits any window.
- R2: Each base is split across a low-half register and a high-half register. A write to one half leaves the other half unchanged, and the full value reads back.
- R3: Windows 0 (configuration) and 1 (message) use a 32-bit mask, and bit 0 of that mask enables the window. Their size is the 32-bit result of ~(mask with bit 0 cleared) + 1. Their mask-high register slot reads 0, and writes to it are ignored.
- R4: The outbound windows (indices 2 up to the last but one) store a 64-bit mask that is read back in full. Their size is the 64-bit result of ~(mask with bit 0 cleared) + 1.
- R5: The last window (the register window) sizes itself like window 0, except that a mask of exactly 0x00007001 gives a size of 4096 bytes.
- R6: An address hits an enabled window when (address − base), taken modulo 2^64, is smaller than the size. The reported offset is that difference. Base + size − 1 hits, while base + size and base − 1 do not.
- R7: A window whose mask bit 0 is clear, or whose computed size is 0, matches no address.
- R8: When several windows match, the lowest index is reported. The order is configuration, message, outbound windows in ascending order, then the register window.
- R9: When no window matches, the hit flag, window index and offset are all 0.
- R10: Register address bits [high:2] select the window index, and bits [1:0] select the field: 0 is mask low, 1 is mask high, 2 is base low, 3 is base high. An address whose window index is not implemented reads 0, and writes to it change nothing.
- R11: A register write takes effect at the clock edge that samples it. The lookup outputs follow the new value from that edge on, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | RA_W (5) | Register address: window index and field |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Combinational readback of regAddr |
| lookAddr | input | 64 | Address to decode |
| lookHit | output | 1 | Some window claims lookAddr |
| lookWin | output | WI_W (3) | Index of the winning window |
| lookOffset | output | 64 | lookAddr minus the winning base |

## Verification
On every cycle, the assertions check four properties of the lookup. A reported hit must lie in an enabled window. Its offset must be below that window's size and must add back to the address. No lower-index window may also match, and a miss must leave all outputs at zero. Some behaviour needs a known register history, so only the bench scenarios can show it. That covers the size arithmetic for each mask kind, the 0x7001 special case, the half-register independence, the ignored writes to unimplemented slots and the exact edge at which a new mask takes effect.

// File: rtl/owd_pkg.sv
package owd_pkg;
  parameter int REG_W  = 32;
  parameter int ADDR_W = 2 * REG_W;

  typedef enum logic [1:0] {
    FLD_MASK_LO = 2'd0,
    FLD_MASK_HI = 2'd1,
    FLD_BASE_LO = 2'd2,
    FLD_BASE_HI = 2'd3
  } fld_e;

  typedef enum logic [1:0] {
    KIND_NARROW = 2'd0,
    KIND_WIDE   = 2'd1,
    KIND_REGWIN = 2'd2
  } kind_e;

  typedef struct packed {
    logic             wrEn;
    fld_e             fld;
    logic [REG_W-1:0] data;
  } wrStrobe_t;

  localparam logic [REG_W-1:0]  REGWIN_MAGIC = 32'h0000_7001;
  localparam logic [ADDR_W-1:0] REGWIN_FIXED = 64'd4096;
  localparam int NARROW_LEADING = 2;

  function automatic kind_e winKind(input int idx, input int numWin);
    if (idx == numWin - 1)          return KIND_REGWIN;
    else if (idx < NARROW_LEADING)  return KIND_NARROW;
    else                            return KIND_WIDE;
  endfunction
endpackage

// File: rtl/owd_ctrl.sv
module owd_ctrl
  import owd_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int RA_W    = 5,
  localparam int WI_W   = RA_W - 2
) (
  input  logic             regWr,
  input  logic [RA_W-1:0]  regAddr,
  input  logic [REG_W-1:0] regWdata,
  output wrStrobe_t        strobe,
  output logic [NUM_WIN-1:0] winWe,
  output logic [WI_W-1:0]  rdWin,
  output fld_e             rdFld,
  output logic             rdValid
);
  logic [WI_W-1:0] winIdx;
  logic            inRange;

  assign winIdx  = regAddr[RA_W-1:2];
  assign inRange = (int'(winIdx) < NUM_WIN);

  assign strobe.wrEn = regWr & inRange;
  assign strobe.fld  = fld_e'(regAddr[1:0]);
  assign strobe.data = regWdata;

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_we
      assign winWe[w] = strobe.wrEn && (winIdx == WI_W'(w));
    end
  endgenerate

  assign rdWin   = winIdx;
  assign rdFld   = fld_e'(regAddr[1:0]);
  assign rdValid = inRange;
endmodule

// File: rtl/owd_datapath.sv
module owd_datapath
  import owd_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int WI_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  wrStrobe_t           strobe,
  input  logic [NUM_WIN-1:0]  winWe,
  input  logic [WI_W-1:0]     rdWin,
  input  fld_e                rdFld,
  input  logic                rdValid,
  input  logic [ADDR_W-1:0]   lookAddr,
  output logic [REG_W-1:0]    regRdata,
  output logic                lookHit,
  output logic [WI_W-1:0]     lookWin,
  output logic [ADDR_W-1:0]   lookOffset,
  output logic [NUM_WIN-1:0]  winEn,
  output logic [NUM_WIN-1:0][ADDR_W-1:0] winBase,
  output logic [NUM_WIN-1:0][ADDR_W-1:0] winSize,
  output logic [NUM_WIN-1:0]  winMatch
);
  logic [NUM_WIN-1:0][ADDR_W-1:0] winDiff;
  logic [NUM_WIN-1:0][3:0][REG_W-1:0] regView;

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam kind_e KIND = winKind(w, NUM_WIN);
      logic [REG_W-1:0]  baseLo, baseHi, maskLo, maskHi;
      logic [ADDR_W-1:0] sizeCalc;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          baseLo <= '0;
          baseHi <= '0;
          maskLo <= '0;
        end else if (winWe[w] && strobe.wrEn) begin
          case (strobe.fld)
            FLD_BASE_LO: baseLo <= strobe.data;
            FLD_BASE_HI: baseHi <= strobe.data;
            FLD_MASK_LO: maskLo <= strobe.data;
            default: ;
          endcase
        end
      end

      if (KIND == KIND_WIDE) begin : g_wide
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)
            maskHi <= '0;
          else if (winWe[w] && strobe.wrEn && strobe.fld == FLD_MASK_HI)
            maskHi <= strobe.data;
        end
        assign sizeCalc = ~({maskHi, maskLo} & ~ADDR_W'(1)) + ADDR_W'(1);
      end else begin : g_narrow
        logic [REG_W-1:0] size32;
        assign maskHi = '0;
        assign size32 = ~(maskLo & ~REG_W'(1)) + REG_W'(1);
        if (KIND == KIND_REGWIN) begin : g_regwin
          assign sizeCalc = (maskLo == REGWIN_MAGIC) ? REGWIN_FIXED
                                                     : {{REG_W{1'b0}}, size32};
        end else begin : g_plain
          assign sizeCalc = {{REG_W{1'b0}}, size32};
        end
      end

      assign winEn[w]    = maskLo[0];
      assign winBase[w]  = {baseHi, baseLo};
      assign winSize[w]  = sizeCalc;
      assign winDiff[w]  = lookAddr - {baseHi, baseLo};
      assign winMatch[w] = maskLo[0] && (winDiff[w] < sizeCalc);

      assign regView[w][0] = maskLo;
      assign regView[w][1] = maskHi;
      assign regView[w][2] = baseLo;
      assign regView[w][3] = baseHi;
    end
  endgenerate

  always_comb begin
    lookHit    = 1'b0;
    lookWin    = '0;
    lookOffset = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (winMatch[w]) begin
        lookHit    = 1'b1;
        lookWin    = WI_W'(w);
        lookOffset = winDiff[w];
      end
    end
  end

  always_comb begin
    regRdata = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (rdValid && rdWin == WI_W'(w))
        regRdata = regView[w][rdFld];
    end
  end
endmodule

// File: rtl/outbound_window_decoder.sv
module outbound_window_decoder
  import owd_pkg::*;
#(
  parameter int NUM_OUT_WIN = 3,
  localparam int NUM_WIN    = NUM_OUT_WIN + 3,
  localparam int WI_W       = $clog2(NUM_WIN),
  localparam int RA_W       = WI_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic [ADDR_W-1:0] lookAddr,
  output logic              lookHit,
  output logic [WI_W-1:0]   lookWin,
  output logic [ADDR_W-1:0] lookOffset
);
  wrStrobe_t            strobe;
  logic [NUM_WIN-1:0]   winWe;
  logic [WI_W-1:0]      rdWin;
  fld_e                 rdFld;
  logic                 rdValid;
  logic [NUM_WIN-1:0]   winEn;
  logic [NUM_WIN-1:0][ADDR_W-1:0] winBase;
  logic [NUM_WIN-1:0][ADDR_W-1:0] winSize;
  logic [NUM_WIN-1:0]   winMatch;

  owd_ctrl #(.NUM_WIN(NUM_WIN), .RA_W(RA_W)) u_ctrl (
    .regWr   (regWr),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .strobe  (strobe),
    .winWe   (winWe),
    .rdWin   (rdWin),
    .rdFld   (rdFld),
    .rdValid (rdValid)
  );

  owd_datapath #(.NUM_WIN(NUM_WIN), .WI_W(WI_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .winWe     (winWe),
    .rdWin     (rdWin),
    .rdFld     (rdFld),
    .rdValid   (rdValid),
    .lookAddr  (lookAddr),
    .regRdata  (regRdata),
    .lookHit   (lookHit),
    .lookWin   (lookWin),
    .lookOffset(lookOffset),
    .winEn     (winEn),
    .winBase   (winBase),
    .winSize   (winSize),
    .winMatch  (winMatch)
  );
endmodule

// File: rtl/owd_checker.sv
module owd_checker
  import owd_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int WI_W    = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   lookAddr,
  input logic                lookHit,
  input logic [WI_W-1:0]     lookWin,
  input logic [ADDR_W-1:0]   lookOffset,
  input logic [NUM_WIN-1:0]  winEn,
  input logic [NUM_WIN-1:0][ADDR_W-1:0] winBase,
  input logic [NUM_WIN-1:0][ADDR_W-1:0] winSize,
  input logic [NUM_WIN-1:0]  winMatch
);
  logic [NUM_WIN-1:0] lowerMask;
  always_comb lowerMask = (NUM_WIN'(1) << lookWin) - NUM_WIN'(1);

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (winEn == '0)); // R1
  AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    lookHit |-> winEn[lookWin]); // R7
  AST_OFFSET_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    lookHit |-> (lookOffset < winSize[lookWin])); // R6
  AST_OFFSET_SUM: assert property (@(posedge clk) disable iff (!rstN)
    lookHit |-> (lookAddr == winBase[lookWin] + lookOffset)); // R6
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    lookHit |-> (winMatch[lookWin] && ((winMatch & lowerMask) == '0))); // R8
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !lookHit |-> (winMatch == '0 && lookWin == '0 && lookOffset == '0)); // R9
endmodule

bind outbound_window_decoder owd_checker #(.NUM_WIN(NUM_WIN), .WI_W(WI_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .lookAddr  (lookAddr),
  .lookHit   (lookHit),
  .lookWin   (lookWin),
  .lookOffset(lookOffset),
  .winEn     (winEn),
  .winBase   (winBase),
  .winSize   (winSize),
  .winMatch  (winMatch)
);

// File: tb/outbound_window_decoder_tb.sv
module outbound_window_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  typedef struct packed {
    logic [63:0] addr;
    logic        hit;
    logic [2:0]  win;
    logic [63:0] off;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{64'h0000_0001_0000_0000, 1'b1, 3'd0, 64'h0},            // R6 cfg base
    '{64'h0000_0001_0000_FFFF, 1'b1, 3'd0, 64'hFFFF},         // R6 last byte
    '{64'h0000_0001_0000_F900, 1'b1, 3'd0, 64'hF900},         // R8 overlap
    '{64'h0000_0001_0001_0000, 1'b1, 3'd1, 64'h800},          // R3 msg
    '{64'h0000_0001_0001_07FF, 1'b1, 3'd1, 64'hFFF},          // R6 msg top
    '{64'h0000_0001_0001_0800, 1'b0, 3'd0, 64'h0},            // R9 past msg
    '{64'h0000_0000_FFFF_FFFF, 1'b0, 3'd0, 64'h0},            // R6 base-1
    '{64'h0000_0008_0FFF_FFFF, 1'b1, 3'd2, 64'h0FFF_FFFF},    // R4 out1
    '{64'h0000_0008_1000_0000, 1'b0, 3'd0, 64'h0},            // R6 base+size
    '{64'h0000_0010_0000_0100, 1'b0, 3'd0, 64'h0},            // R7 out2 off
    '{64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 3'd4, 64'hFFFF_FFFF},    // R4 out3 top
    '{64'h0000_0000_2000_0FFF, 1'b1, 3'd5, 64'hFFF},          // R5 magic
    '{64'h0000_0000_2000_1000, 1'b0, 3'd0, 64'h0},            // R5 magic end
    '{64'h0000_0000_0000_0000, 1'b0, 3'd0, 64'h0}             // R9 zero
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [63:0] lookAddr = '0;
  logic        lookHit;
  logic [2:0]  lookWin;
  logic [63:0] lookOffset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  outbound_window_decoder u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .lookAddr(lookAddr),
    .lookHit(lookHit), .lookWin(lookWin), .lookOffset(lookOffset)
  );

  function automatic logic [4:0] ra(input int win, input int fld);
    return 5'(win * 4 + fld);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(req, 64'(regRdata), 64'(exp));
  endtask

  task automatic look(input string req, input logic [63:0] a, input logic h,
                      input logic [2:0] w, input logic [63:0] o);
    @(negedge clk);
    lookAddr = a;
    #1;
    chk(req, 64'(lookHit), 64'(h));
    chk(req, 64'(lookWin), 64'(w));
    chk(req, lookOffset, o);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: every mapped register reads 0 and nothing hits after reset
    for (int a = 0; a < 24; a++) rd("R1 reset readback", 5'(a), 32'h0);
    look("R1 reset no hit", 64'h0, 1'b0, 3'd0, 64'h0);

    // Program the window set used by the vector table
    wr(ra(0, 3), 32'h1);          wr(ra(0, 2), 32'h0);         wr(ra(0, 0), 32'hFFFF_0001);
    wr(ra(1, 3), 32'h1);          wr(ra(1, 2), 32'h0000_F800); wr(ra(1, 0), 32'hFFFF_F001);
    wr(ra(2, 3), 32'h8);          wr(ra(2, 2), 32'h0);
    wr(ra(2, 1), 32'hFFFF_FFFF);  wr(ra(2, 0), 32'hF000_0001);
    wr(ra(3, 3), 32'h10);         wr(ra(3, 2), 32'h0);
    wr(ra(3, 1), 32'hFFFF_FFFF);  wr(ra(3, 0), 32'h0);
    wr(ra(4, 3), 32'hFFFF_FFFF);  wr(ra(4, 2), 32'h0);
    wr(ra(4, 1), 32'hFFFF_FFFF);  wr(ra(4, 0), 32'h1);
    wr(ra(5, 3), 32'h0);          wr(ra(5, 2), 32'h2000_0000); wr(ra(5, 0), 32'h7001);

    for (int i = 0; i < NVEC; i++)
      look($sformatf("R6/R8 vector %0d", i), VECS[i].addr, VECS[i].hit, VECS[i].win, VECS[i].off);

    // R4: wide mask reads back in full
    rd("R4 mask high readback", ra(2, 1), 32'hFFFF_FFFF);
    rd("R4 mask low readback", ra(2, 0), 32'hF000_0001);

    // R3: narrow window mask-high slot ignores writes
    wr(ra(0, 1), 32'h1234_5678);
    rd("R3 mask high reads 0", ra(0, 1), 32'h0);
    look("R3 cfg unchanged", 64'h0000_0001_0000_0010, 1'b1, 3'd0, 64'h10);

    // R10: unimplemented window slots read 0, writes change nothing
    wr(5'd24, 32'hFFFF_FFFF);
    wr(5'd27, 32'hFFFF_FFFF);
    rd("R10 unmapped reads 0", 5'd24, 32'h0);
    rd("R10 unmapped reads 0", 5'd27, 32'h0);
    look("R10 lookup unchanged", 64'h0000_0008_0000_0004, 1'b1, 3'd2, 64'h4);

    // R5: a mask other than the magic value follows the normal rule
    wr(ra(5, 0), 32'h7003);
    look("R5 normal rule", 64'h0000_0000_2001_0000, 1'b1, 3'd5, 64'h10000);

    // R11: new mask takes effect at the sampling edge, not before
    @(negedge clk);
    regWr = 1'b1; regAddr = ra(5, 0); regWdata = 32'h7001;
    lookAddr = 64'h0000_0000_2001_0000;
    #1;
    chk("R11 before edge", 64'(lookHit), 64'h1);
    @(posedge clk);
    #1;
    chk("R11 after edge", 64'(lookHit), 64'h0);
    @(negedge clk);
    regWr = 1'b0;

    // R7/R8: disabling cfg lets msg claim the overlap
    wr(ra(0, 0), 32'hFFFF_0000);
    look("R8 fallback to msg", 64'h0000_0001_0000_FA00, 1'b1, 3'd1, 64'h200);
    look("R7 disabled cfg", 64'h0000_0001_0000_0000, 1'b0, 3'd0, 64'h0);

    // R7: enabled window of size 0 matches nothing
    wr(ra(1, 0), 32'h0000_0001);
    look("R7 zero size", 64'h0000_0001_0001_0000, 1'b0, 3'd0, 64'h0);

    // R2: half writes are independent
    wr(ra(0, 2), 32'hABCD_0000);
    rd("R2 base high kept", ra(0, 3), 32'h1);
    rd("R2 base low written", ra(0, 2), 32'hABCD_0000);
    wr(ra(0, 3), 32'h2);
    rd("R2 base low kept", ra(0, 2), 32'hABCD_0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule